// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block places a small direct-mapped cache between a processor-side word port and a main-memory port. Each byte address is cut into three parts. The low bits pick a byte inside the word and the cache ignores them. The middle bits pick one of 2^k lines. The upper bits form the tag, which is stored next to the line. Every line holds one data word, its tag, a valid flag and a dirty flag.

A hit completes in the same cycle the request is seen. A read hit returns the stored word, and a write hit replaces the stored word and marks the line modified. On a miss the processor is held and the cache fetches the word from memory. If the line being replaced holds modified data, that word is first written back to its own memory address. A clean line is simply overwritten. Write misses allocate: the word is fetched first, and the held write then lands on the freshly filled line as an ordinary hit.

Top module: `dmCache`

## Requirements
- R1: The byte address is split as follows. Bits [OFF_W-1:0] select a byte and never affect the result, where OFF_W = log2(DATA_W/8), which is 2 for 32-bit words. Bits [OFF_W+IDX_W-1:OFF_W] form the line index. The remaining upper bits form the tag.
- R2: Reset clears every valid flag, so the first access to any line after reset misses and issues a memory read.
- R3: A hit requires a valid line whose stored tag equals the address tag. A hit raises cpuReady in the same cycle as cpuReq, returns the cached word on a read, and causes no memory transaction.
- R4: Two addresses whose difference is a multiple of 2^(IDX_W+OFF_W) bytes use the same line, and accessing one evicts the other.
- R5: A fill writes the word from memory into the line, sets its valid flag and leaves it clean.
- R6: A write hit replaces the cached word and sets the line's dirty flag, without writing memory.
- R7: On a miss whose victim is valid and dirty, the victim word is first written to memory at the address formed from the victim's stored tag and index. Only after that write is acknowledged is the new word read.
- R8: On a miss whose victim is clean or invalid, no memory write happens, and the line is overwritten by the fill.
- R9: A write miss reads the line from memory and then merges the write into the cache. The write data does not reach memory during that access.
- R10: memReq, memWe, memAddr and memWdata stay stable while memReq is high and memAck is low. memAck may arrive after any number of cycles, and one memAck cycle completes one transaction.
- R11: cpuReady is high only while cpuReq is high, and never while a memory transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request; held with its address and data until cpuReady |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | DATA_W | Write word |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read word, valid with cpuReady |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = write-back, 0 = fill read |
| memAddr | output | ADDR_W | Word-aligned memory byte address |
| memWdata | output | DATA_W | Write-back word |
| memAck | input | 1 | One-cycle completion from memory |
| memRdata | input | DATA_W | Fill word, valid with memAck |

## Verification
Directed accesses come first. They cover a cold miss, a repeat hit at a different byte offset, a write hit, a conflicting read that evicts a dirty line, a conflict against a clean line, and a write miss. Each case is told apart by how many write-backs and fills memory sees, plus the victim address and data. Random reads and writes then run over a 256-word window, so that tags collide often under a memory with a random latency of 0 to 3 cycles. This separates hits from clean and dirty evictions, and the write-back order and data are checked against a line-state model held in the bench.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  // strobes from the controller to the line store
  typedef struct packed {
    logic fillLine;   // load word from memory, mark valid and clean
    logic writeWord;  // merge processor write, mark dirty
  } dmcStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } dmcState_t;
endpackage

// File: rtl/dmcDatapath.sv
module dmcDatapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmcStrobe_t        strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] lineData
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [TAG_W-1:0] tagQ  [LINES];
  logic [DATA_W-1:0] dataQ [LINES];
  logic [LINES-1:0] validQ;
  logic [LINES-1:0] dirtyQ;

  assign idx = cpuAddr[OFF_W +: IDX_W];
  assign tag = cpuAddr[ADDR_W-1 -: TAG_W];

  assign hit         = validQ[idx] && (tagQ[idx] == tag);
  assign victimDirty = validQ[idx] && dirtyQ[idx];
  assign victimAddr  = {tagQ[idx], idx, {OFF_W{1'b0}}};
  assign lineData    = dataQ[idx];

  // flags: reset clears all valid bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (strb.fillLine) begin
      validQ[idx] <= 1'b1;
      dirtyQ[idx] <= 1'b0;
    end else if (strb.writeWord) begin
      dirtyQ[idx] <= 1'b1;
    end
  end

  // tag and data storage, no reset needed
  always_ff @(posedge clk) begin
    if (strb.fillLine) begin
      tagQ[idx]  <= tag;
      dataQ[idx] <= memRdata;
    end else if (strb.writeWord) begin
      dataQ[idx] <= cpuWdata;
    end
  end

  // R5
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLine |=> validQ[$past(idx)] && !dirtyQ[$past(idx)]);

  // R6
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeWord |=> dirtyQ[$past(idx)] && dataQ[$past(idx)] == $past(cpuWdata));
endmodule

// File: rtl/dmcControl.sv
module dmcControl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       memAck,
  output dmcStrobe_t strb,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWe,
  output logic       selVictim
);
  dmcState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD         = stateQ;
    strb.fillLine  = 1'b0;
    strb.writeWord = 1'b0;
    cpuReady       = 1'b0;
    memReq         = 1'b0;
    memWe          = 1'b0;
    selVictim      = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cpuReq && hit) begin
          cpuReady       = 1'b1;
          strb.writeWord = cpuWe;
        end else if (cpuReq) begin
          stateD = victimDirty ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        selVictim = 1'b1;
        if (memAck) stateD = ST_FILL;
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.fillLine = 1'b1;
          stateD        = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && memWe == $past(memWe));

  // R7
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck |=> memReq && !memWe);

  // R11
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq && !memReq);
endmodule

// File: rtl/dmCache.sv
module dmCache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  dmcStrobe_t        strb;
  logic              hit, victimDirty, selVictim;
  logic [ADDR_W-1:0] victimAddr;
  logic [DATA_W-1:0] lineData;

  dmcDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .hit(hit),
    .victimDirty(victimDirty), .victimAddr(victimAddr), .lineData(lineData)
  );

  dmcControl uCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .victimDirty(victimDirty), .memAck(memAck), .strb(strb),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe), .selVictim(selVictim)
  );

  assign memAddr  = selVictim ? victimAddr
                              : {cpuAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign memWdata = lineData;
  assign cpuRdata = lineData;

  // R8
  wb_dirty_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> victimDirty);

  // R10
  mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWdata));
endmodule

// File: tb/sim_dmCache.sv
`timescale 1ns/1ps
module sim_dmCache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic        cpuReady;
  logic [31:0] cpuRdata;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  dmCache #(.ADDR_W(32), .DATA_W(32), .IDX_W(4)) u0 (.*);

  // backing memory and the processor-visible image (256 words)
  logic [31:0] mem    [256];
  logic [31:0] shadow [256];
  // bench line model: 16 lines, 4-bit tag over the window
  logic [15:0] mV, mD;
  logic [3:0]  mT [16];

  int wbCnt = 0, fillCnt = 0, opCnt = 0, wbOrd = 0, fillOrd = 0;
  int holdErr = 0;
  logic [31:0] lastWbAddr, lastWbData, startAddr;

  function automatic logic [31:0] initWord(int i);
    return 32'h5a00_0000 ^ (i * 32'h0001_9e37) ^ 32'h7;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder: random 0..3 cycle latency, one-cycle ack
  initial begin
    int lat = 0;
    bit busy = 0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq && rstN) begin
        if (!busy) begin busy = 1; lat = $urandom % 4; startAddr = memAddr; end
        if (memAddr != startAddr) holdErr++;
        if (lat == 0) begin
          busy = 0;
          memAck = 1'b1;
          if (memAddr[31:10] != 0) holdErr++;
          if (memWe) begin
            mem[memAddr[9:2]] = memWdata;
            lastWbAddr = memAddr; lastWbData = memWdata;
            wbCnt++; wbOrd = opCnt++;
          end else begin
            memRdata = mem[memAddr[9:2]];
            fillCnt++; fillOrd = opCnt++;
          end
        end else lat--;
      end
    end
  end

  task automatic doAccess(input logic we, input logic [7:0] wa, input logic [1:0] off,
                          input logic [31:0] wd);
    logic [3:0] idx = wa[3:0];
    logic [3:0] tg  = wa[7:4];
    logic expHit = mV[idx] && mT[idx] == tg;
    logic expWb  = !expHit && mV[idx] && mD[idx];
    logic [7:0] vWa = {mT[idx], idx};
    logic [31:0] memBefore = mem[wa];
    int wb0 = wbCnt, f0 = fillCnt, h0 = holdErr, waited = 0;
    logic [31:0] rd;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = {22'd0, wa, off}; cpuWdata = wd;
    #1;
    while (!cpuReady) begin @(negedge clk); #1; waited++; end
    rd = cpuRdata;
    @(posedge clk); #1 cpuReq = 1'b0;
    if (!we) chk(rd == shadow[wa], "R3 read data", rd, shadow[wa]);
    if (expHit) chk(waited == 0, "R3 hit latency", waited, 0);
    chk((fillCnt - f0) == (expHit ? 0 : 1), "R5 fill count", fillCnt - f0, expHit ? 0 : 1);
    if (expWb) begin
      chk(wbCnt - wb0 == 1, "R7 write-back count", wbCnt - wb0, 1);
      chk(lastWbAddr == {22'd0, vWa, 2'b00}, "R7 victim address", lastWbAddr, {22'd0, vWa, 2'b00});
      chk(lastWbData == shadow[vWa], "R7 victim data", lastWbData, shadow[vWa]);
      chk(wbOrd < fillOrd, "R7 order", wbOrd, fillOrd);
    end else begin
      chk(wbCnt == wb0, "R8 no write-back", wbCnt - wb0, 0);
    end
    if (we) chk(mem[wa] == memBefore, "R9 memory untouched by write", mem[wa], memBefore);
    chk(holdErr == h0, "R10 memory request hold", holdErr - h0, 0);
    if (we) shadow[wa] = wd;
    if (!expHit) begin mV[idx] = 1'b1; mT[idx] = tg; mD[idx] = 1'b0; end
    if (we) mD[idx] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int f0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin mem[i] = initWord(i); shadow[i] = initWord(i); end
    mV = '0; mD = '0;
    for (int i = 0; i < 16; i++) mT[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(cpuReady == 1'b0, "R11 ready low at reset", cpuReady, 0);
    chk(memReq == 1'b0, "R2 no memory request at reset", memReq, 0);
    // R2: cold miss
    f0 = fillCnt;
    doAccess(1'b0, 8'h12, 2'd0, 0);
    chk(fillCnt - f0 == 1, "R2 cold miss fills", fillCnt - f0, 1);
    // R1: other byte offset hits the same word
    f0 = fillCnt;
    doAccess(1'b0, 8'h12, 2'd3, 0);
    chk(fillCnt == f0, "R1 offset ignored", fillCnt - f0, 0);
    // R6: write hit stays in cache
    doAccess(1'b1, 8'h12, 2'd1, 32'hdead_beef);
    chk(mem[8'h12] == initWord(8'h12), "R6 memory not written", mem[8'h12], initWord(8'h12));
    doAccess(1'b0, 8'h12, 2'd2, 0);
    // R4: conflict 64 bytes apart, dirty victim
    doAccess(1'b0, 8'h22, 2'd0, 0);
    chk(mem[8'h12] == 32'hdead_beef, "R4 evicted dirty word", mem[8'h12], 32'hdead_beef);
    f0 = fillCnt;
    doAccess(1'b0, 8'h12, 2'd0, 0);
    chk(fillCnt - f0 == 1, "R4 evicted line misses", fillCnt - f0, 1);
    // R8: clean victim
    doAccess(1'b0, 8'h32, 2'd0, 0);
    // R9: write miss allocates then merges
    doAccess(1'b1, 8'h45, 2'd0, 32'h1234_5678);
    doAccess(1'b0, 8'h45, 2'd0, 0);
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] wa = 8'($urandom);
      if ($urandom % 3 == 0) wa[7:6] = 2'b00;
      doAccess(1'($urandom % 2), wa, 2'($urandom), $urandom);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule